// File: doc/BRIEF.md
# Packed Word Multiply with Pairwise Doubleword Sum

This unit takes two 64-bit operands, each holding four signed 16-bit words, multiplies the words that share a lane, and adds the products in adjacent pairs. The result is a 64-bit value holding two 32-bit signed sums. The output therefore has half as many lanes as the inputs, and each output lane is twice as wide. Typical uses are dot products and filter taps over packed sample data.

Operands enter through a valid/ready handshake. The arithmetic runs over two register stages, so a result appears two cycles after its operands are accepted. A whole-pipeline stall holds every stage when the consumer is not ready. A generate-time option sets where the stage boundary sits: after the multipliers, or in front of them.

Top module: `pmadd_unit`

## Requirements
- R1: Lane k of each operand is bits [16k+15:16k], for k = 0..3, and lane k of `op_a` is paired only with lane k of `op_b`.
- R2: `result[63:32]` equals a3*b3 + a2*b2.
- R3: `result[31:0]` equals a1*b1 + a0*b0.
- R4: Lanes are signed two's complement, and each product is the full signed 32-bit value (for example, 0x7FFF times 0x8000 gives -1073709056).
- R5: Each sum wraps modulo 2^32. With all four words of a pair at 0x8000, that sum reads 0x80000000.
- R6: With `out_ready` high, `out_valid` rises exactly two clock edges after the edge on which `in_valid && in_ready` was seen, and the result belongs to that accepted input.
- R7: While `out_valid` is high and `out_ready` is low, `in_ready` is low, and `out_valid` and `result` hold their values.
- R8: After reset, `out_valid` is 0 and `in_ready` is 1.
- R9: A cycle with `in_valid` low, while the unit is accepting, produces no output: two edges later `out_valid` is 0.
- R10: Results leave in the order their inputs were accepted, one per cycle when inputs arrive back to back and `out_ready` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands on `op_a`/`op_b` are valid |
| in_ready | output | 1 | Unit can take operands this cycle |
| op_a | input | 64 | Four packed signed 16-bit words |
| op_b | input | 64 | Four packed signed 16-bit words |
| out_valid | output | 1 | `result` holds a finished pair of sums |
| out_ready | input | 1 | Consumer takes `result` this cycle |
| result | output | 64 | Two packed signed 32-bit sums |

## Verification
The hardest case to reach from the ports is a stall that starts while both stages hold live data and new operands are still being offered. The output must then keep its value, and nothing may be dropped or duplicated when the stall ends. The stimulus reaches this state by feeding three operand sets on consecutive cycles while `out_ready` is held low, keeping the third offered across the stall, and then releasing `out_ready`. It checks that the three results leave in order. The one overflow case, where all four words of a pair are 0x8000, is driven directly from the vector table.

// File: rtl/pmadd_pkg.sv
package pmadd_pkg;
   // Where the stage-1 register sits.
   typedef enum logic {
      CUT_AFTER_MUL  = 1'b0,  // stage 1 holds products
      CUT_BEFORE_MUL = 1'b1   // stage 1 holds operands
   } cut_e;

   localparam int unsigned DEF_LANE_W = 16;
   localparam int unsigned DEF_LANES  = 4;
endpackage

// File: rtl/pmadd_lane_mul.sv
module pmadd_lane_mul #(
   parameter int unsigned LANE_W = 16,
   localparam int unsigned PROD_W = 2 * LANE_W
) (
   input  logic [LANE_W-1:0] a_lane,
   input  logic [LANE_W-1:0] b_lane,
   output logic [PROD_W-1:0] prod
);
   logic signed [PROD_W-1:0] a_ext;
   logic signed [PROD_W-1:0] b_ext;

   always_comb begin
      a_ext = PROD_W'($signed(a_lane));
      b_ext = PROD_W'($signed(b_lane));
      prod  = a_ext * b_ext;
   end
endmodule

// File: rtl/pmadd_pair_add.sv
module pmadd_pair_add #(
   parameter int unsigned SUM_W = 32
) (
   input  logic [SUM_W-1:0] p_hi,
   input  logic [SUM_W-1:0] p_lo,
   output logic [SUM_W-1:0] sum
);
   // Plain modular add: the carry out is dropped on purpose.
   always_comb sum = p_hi + p_lo;
endmodule

// File: rtl/pmadd_ctrl.sv
module pmadd_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic in_valid,
   input  logic out_ready,
   output logic advance,
   output logic s1_valid,
   output logic s2_valid
);
   // The whole pipeline moves together. It stops only when a finished
   // result is waiting and the consumer refuses it.
   always_comb advance = !s2_valid || out_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_valid <= 1'b0;
         s2_valid <= 1'b0;
      end else if (advance) begin
         s1_valid <= in_valid;
         s2_valid <= s1_valid;
      end
   end
endmodule

// File: rtl/pmadd_unit.sv
module pmadd_unit
   import pmadd_pkg::*;
#(
   parameter int unsigned LANE_W = DEF_LANE_W,
   parameter int unsigned LANES  = DEF_LANES,
   parameter cut_e        CUT    = CUT_AFTER_MUL,
   localparam int unsigned OP_W   = LANE_W * LANES,
   localparam int unsigned PROD_W = 2 * LANE_W,
   localparam int unsigned PAIRS  = LANES / 2,
   localparam int unsigned RES_W  = PAIRS * PROD_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic [OP_W-1:0]  op_a,
   input  logic [OP_W-1:0]  op_b,
   output logic             out_valid,
   input  logic             out_ready,
   output logic [RES_W-1:0] result
);
   // Parameter checks at elaboration
   if (LANES < 2 || (LANES % 2) != 0) begin : g_bad_lanes
      $error("pmadd_unit: LANES must be even and at least 2");
   end
   if (LANE_W < 2) begin : g_bad_width
      $error("pmadd_unit: LANE_W must be at least 2");
   end

   logic advance;
   logic s1_valid;
   logic s2_valid;

   pmadd_ctrl ctrl_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .out_ready(out_ready),
      .advance  (advance),
      .s1_valid (s1_valid),
      .s2_valid (s2_valid)
   );

   // Products seen by the adders, in lane order
   logic [LANES*PROD_W-1:0] prod_use;

   if (CUT == CUT_AFTER_MUL) begin : g_cut_after
      logic [LANES*PROD_W-1:0] prod_now;
      logic [LANES*PROD_W-1:0] prod_q;
      for (genvar k = 0; k < LANES; k++) begin : g_mul
         pmadd_lane_mul #(.LANE_W(LANE_W)) mul_i (
            .a_lane(op_a[k*LANE_W +: LANE_W]),
            .b_lane(op_b[k*LANE_W +: LANE_W]),
            .prod  (prod_now[k*PROD_W +: PROD_W])
         );
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       prod_q <= '0;
         else if (advance) prod_q <= prod_now;
      end
      always_comb prod_use = prod_q;
   end else begin : g_cut_before
      logic [OP_W-1:0] a_q;
      logic [OP_W-1:0] b_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            a_q <= '0;
            b_q <= '0;
         end else if (advance) begin
            a_q <= op_a;
            b_q <= op_b;
         end
      end
      for (genvar k = 0; k < LANES; k++) begin : g_mul
         pmadd_lane_mul #(.LANE_W(LANE_W)) mul_i (
            .a_lane(a_q[k*LANE_W +: LANE_W]),
            .b_lane(b_q[k*LANE_W +: LANE_W]),
            .prod  (prod_use[k*PROD_W +: PROD_W])
         );
      end
   end

   // Horizontal pairwise add: lanes 2p+1 and 2p feed output lane p
   logic [RES_W-1:0] sum_now;
   logic [RES_W-1:0] res_q;

   for (genvar p = 0; p < PAIRS; p++) begin : g_pair
      pmadd_pair_add #(.SUM_W(PROD_W)) add_i (
         .p_hi(prod_use[(2*p+1)*PROD_W +: PROD_W]),
         .p_lo(prod_use[(2*p)*PROD_W +: PROD_W]),
         .sum (sum_now[p*PROD_W +: PROD_W])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       res_q <= '0;
      else if (advance) res_q <= sum_now;
   end

   always_comb begin
      in_ready  = advance;
      out_valid = s2_valid;
      result    = res_q;
   end

   // R7
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(result)));

   // R6
   accept_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) ##1 in_ready |=> out_valid);

   // R9
   bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_valid && in_ready) ##1 in_ready |=> !out_valid);

   // R8
   reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!out_valid && in_ready));
endmodule

// File: tb/pmadd_unit_tb_top.sv
module pmadd_unit_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [63:0] op_a = '0;
   logic [63:0] op_b = '0;
   logic        out_valid;
   logic        out_ready = 1'b1;
   logic [63:0] result;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;  // 50 MHz

   pmadd_unit dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .op_a(op_a), .op_b(op_b), .out_valid(out_valid), .out_ready(out_ready),
      .result(result)
   );

   typedef struct packed {
      logic [63:0] a;
      logic [63:0] b;
      logic [63:0] exp;
   } vec_t;

   localparam int NVEC = 6;
   localparam vec_t VECS [NVEC] = '{
      '{64'h0001_0001_0001_0001, 64'h0002_0002_0002_0002, 64'h00000004_00000004},
      '{64'h0003_FFFE_0005_0007, 64'h0004_0006_FFFD_0002, 64'h00000000_FFFFFFFF},
      '{64'h8000_8000_8000_8000, 64'h8000_8000_8000_8000, 64'h80000000_80000000},
      '{64'h7FFF_7FFF_7FFF_7FFF, 64'h8000_8000_8000_8000, 64'h80010000_80010000},
      '{64'hFFFF_FFFF_FFFF_FFFF, 64'h7FFF_0001_FFFF_8000, 64'hFFFF8000_00008001},
      '{64'h0001_0000_0000_0000, 64'h0005_0000_0000_0000, 64'h00000005_00000000}
   };
   localparam string VTAG [NVEC] = '{"R2 R3", "R4", "R5", "R4", "R1", "R1"};

   function automatic logic [63:0] model(input logic [63:0] a, input logic [63:0] b);
      logic signed [31:0] hi;
      logic signed [31:0] lo;
      hi = 32'($signed(a[63:48])) * 32'($signed(b[63:48]))
         + 32'($signed(a[47:32])) * 32'($signed(b[47:32]));
      lo = 32'($signed(a[31:16])) * 32'($signed(b[31:16]))
         + 32'($signed(a[15:0]))  * 32'($signed(b[15:0]));
      return {hi, lo};
   endfunction

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(20 * 200000);
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
   end

   initial begin
      // R8: reset state
      repeat (3) @(negedge clk);
      check("R8 out_valid", 64'(out_valid), 64'd0);
      check("R8 in_ready", 64'(in_ready), 64'd1);
      rst_n = 1'b1;
      @(negedge clk);
      check("R8 out_valid after release", 64'(out_valid), 64'd0);

      // Vector table: R1 to R6, one input at a time
      for (int i = 0; i < NVEC; i++) begin
         op_a = VECS[i].a; op_b = VECS[i].b; in_valid = 1'b1; out_ready = 1'b1;
         @(negedge clk);
         in_valid = 1'b0;
         check("R6 no early output", 64'(out_valid), 64'd0);
         @(negedge clk);
         check("R6 out_valid at two edges", 64'(out_valid), 64'd1);
         check(VTAG[i], result, VECS[i].exp);
      end

      // R9: bubbles produce no output
      in_valid = 1'b0;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         check("R9 bubble", 64'(out_valid), 64'd0);
      end

      // R10: back-to-back stream against the model
      begin
         logic [63:0] sa [6];
         logic [63:0] sb [6];
         for (int j = 0; j < 6; j++) begin
            sa[j] = {4{16'(j * 16'h3A7F)}} ^ 64'h8001_7FFF_0123_FEDC;
            sb[j] = {16'(j * 977), 16'h8000 - 16'(j), 16'(j * 16'h1111), 16'hFFFF - 16'(j * 5)};
         end
         for (int j = 0; j < 8; j++) begin
            if (j >= 2) begin
               check("R10 stream valid", 64'(out_valid), 64'd1);
               check("R10 stream order", result, model(sa[j-2], sb[j-2]));
            end
            if (j < 6) begin
               op_a = sa[j]; op_b = sb[j]; in_valid = 1'b1;
            end else begin
               in_valid = 1'b0;
            end
            @(negedge clk);
         end
      end

      // R7: stall with both stages full and new data offered
      out_ready = 1'b0;
      op_a = VECS[1].a; op_b = VECS[1].b; in_valid = 1'b1;
      @(negedge clk);
      op_a = VECS[2].a; op_b = VECS[2].b;
      @(negedge clk);
      check("R7 first result valid", 64'(out_valid), 64'd1);
      check("R7 in_ready low in stall", 64'(in_ready), 64'd0);
      op_a = VECS[4].a; op_b = VECS[4].b;
      @(negedge clk);
      check("R7 held valid", 64'(out_valid), 64'd1);
      check("R7 held result", result, VECS[1].exp);
      check("R7 still refusing", 64'(in_ready), 64'd0);
      @(negedge clk);
      check("R7 held result later", result, VECS[1].exp);
      out_ready = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check("R7 second after release", result, VECS[2].exp);
      @(negedge clk);
      check("R7 third after release", result, VECS[4].exp);
      @(negedge clk);
      check("R7 drained", 64'(out_valid), 64'd0);

      finish_run();
   end
endmodule